// File: doc/BRIEF.md
# Base Address Register Decode Validator

This block looks at one base address register slot of a PCI function and decides whether its current contents decode to a usable address window. It combines the raw register value, the region size, the region kind (I/O, 32-bit memory or 64-bit memory), an expansion-ROM marker and the two space-enable bits of the command register. From these it produces either the aligned base address or an "unmapped" result.

The decision is made combinationally and then registered, so the outputs follow the inputs with one clock of latency. A one-cycle update pulse tells the downstream address-map logic that the registered result has changed and a remap is needed. A slot whose size input is zero is treated as not implemented.

Top module: `bar_decode_valid`

## Requirements
- R1: While reset is held and after its release with no change in the inputs, the block reports base all-ones, mapped low and update low.
- R2: An I/O region is unmapped when `io_space_en` is low. A memory region, including the ROM slot, is unmapped when `mem_space_en` is low.
- R3: The candidate base is the register value with its low log2(size) bits cleared, and the last address is base + size - 1. A 64-bit memory region takes its value as {`bar_hi`, `bar_lo`}. I/O and 32-bit memory regions use `bar_lo` alone and ignore `bar_hi`.
- R4: An I/O region is unmapped when its base is zero, when its last address is not above its base, or when its last address exceeds 0xFFFF.
- R5: A ROM slot (`is_rom` high, memory type) is unmapped unless bit 0 of `bar_lo` is set.
- R6: A memory region is unmapped when its base is zero, when its last address is not above its base, or when its last address is 64-bit all-ones.
- R7: A 32-bit memory region is unmapped when its last address is at or above 0xFFFFFFFF. A 64-bit region is not limited this way.
- R8: An unmapped result drives `base_addr` to all-ones and `mapped` low. A mapped result drives `mapped` high with the aligned base.
- R9: `update` is high for exactly the one cycle in which the registered base or mapped flag has just changed. It stays low while the result is unchanged.
- R10: With `region_size` zero the slot always reports unmapped, and `update` stays low while the size remains zero.
- R11: A change on the inputs before a rising clock edge appears on `base_addr` and `mapped` right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bar_lo | input | 32 | Low register word; bit 0 is the ROM enable |
| bar_hi | input | 32 | High register word, used by 64-bit memory regions only |
| region_size | input | 64 | Region size, a power of two, or zero if not implemented |
| is_io | input | 1 | 1 = I/O region, 0 = memory region |
| is_mem64 | input | 1 | Memory region uses 64-bit addressing |
| is_rom | input | 1 | Slot is the expansion ROM |
| io_space_en | input | 1 | Command register I/O space enable |
| mem_space_en | input | 1 | Command register memory space enable |
| base_addr | output | 64 | Decoded base, all-ones when unmapped |
| mapped | output | 1 | Result decodes to a valid window |
| update | output | 1 | One-cycle pulse after the result changed |

## Verification
The assertions assume that `region_size` is either zero or a single set bit, and that `is_rom` is only raised together with a memory type. The bench therefore uses only power-of-two sizes and zero, and it never marks an I/O slot as ROM. Several properties relate one cycle of inputs to the next cycle of outputs. For that reason each stimulus vector is held for a full clock, and every expected value is taken just after the edge that registers it.

// File: rtl/bar_decode_valid.sv
module bar_decode_valid #(
  parameter int          AW      = 64,
  parameter logic [63:0] IO_CEIL = 64'h0000_0000_0000_FFFF,
  parameter logic [63:0] M32_TOP = 64'h0000_0000_FFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   bar_lo,
  input  logic [31:0]   bar_hi,
  input  logic [AW-1:0] region_size,
  input  logic          is_io,
  input  logic          is_mem64,
  input  logic          is_rom,
  input  logic          io_space_en,
  input  logic          mem_space_en,
  output logic [AW-1:0] base_addr,
  output logic          mapped,
  output logic          update
);
  localparam logic [AW-1:0] ONES = {AW{1'b1}};

  logic [AW-1:0] raw, cand, last, nxt_base;
  logic          sane, io_ok, mem_ok, nxt_map;

  assign raw  = (!is_io && is_mem64) ? AW'({bar_hi, bar_lo}) : AW'(bar_lo);
  assign cand = raw & ~(region_size - AW'(1));
  assign last = cand + region_size - AW'(1);
  assign sane = (last > cand) && (cand != '0);

  assign io_ok  = io_space_en && sane && (last <= AW'(IO_CEIL));
  assign mem_ok = mem_space_en && sane && (last != ONES) &&
                  (!is_rom || bar_lo[0]) &&
                  (is_mem64 || last < AW'(M32_TOP));

  assign nxt_map  = (region_size != '0) && (is_io ? io_ok : mem_ok);
  assign nxt_base = nxt_map ? cand : ONES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= ONES;
      mapped    <= 1'b0;
      update    <= 1'b0;
    end else begin
      base_addr <= nxt_base;
      mapped    <= nxt_map;
      update    <= (nxt_base != base_addr) || (nxt_map != mapped);
    end
  end
endmodule

// File: rtl/bar_decode_valid_sva.sv
module bar_decode_valid_sva #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   bar_lo,
  input logic [AW-1:0] region_size,
  input logic          is_io,
  input logic          is_rom,
  input logic          io_space_en,
  input logic          mem_space_en,
  input logic [AW-1:0] base_addr,
  input logic          mapped,
  input logic          update
);
  p_io_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_io && !io_space_en) |=> !mapped);

  p_mem_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_io && !mem_space_en) |=> !mapped);

  p_rom_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_io && is_rom && !bar_lo[0]) |=> !mapped);

  p_unmapped_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (base_addr == {AW{1'b1}}));

  p_mapped_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mapped |-> (base_addr != '0));

  p_pulse_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> (base_addr != $past(base_addr) || mapped != $past(mapped)));

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> (!update || base_addr != $past(base_addr) || mapped != $past(mapped)));

  p_zero_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (region_size == '0) |=> !mapped);
endmodule

bind bar_decode_valid bar_decode_valid_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .bar_lo(bar_lo), .region_size(region_size),
  .is_io(is_io), .is_rom(is_rom), .io_space_en(io_space_en),
  .mem_space_en(mem_space_en), .base_addr(base_addr), .mapped(mapped),
  .update(update));

// File: tb/tb_bar_decode_valid.sv
`timescale 1ns/1ps
module tb_bar_decode_valid;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct {
    logic [63:0] base;
    logic        map;
    logic        upd;
    string       tag;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic [31:0] bar_lo = 0, bar_hi = 0;
  logic [63:0] region_size = 0;
  logic        is_io = 0, is_mem64 = 0, is_rom = 0, io_space_en = 0, mem_space_en = 0;
  logic [63:0] base_addr;
  logic        mapped, update;

  int compared = 0, mismatched = 0;
  exp_t q[$];
  logic [63:0] prev_base = ONES;
  logic        prev_map = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  bar_decode_valid dut (.*);

  function automatic void model(input logic [31:0] lo, hi, input logic [63:0] sz,
                                input logic io, m64, rom, ioe, me,
                                output logic [63:0] b, output logic m);
    logic [63:0] v, c, l;
    m = 0;
    b = ONES;
    if (sz == 0) return;
    if (io) begin
      v = {32'h0, lo};
      c = v & ~(sz - 1);
      l = c + sz - 1;
      if (ioe && c != 0 && l > c && l <= 64'hFFFF) m = 1;
    end else begin
      v = m64 ? {hi, lo} : {32'h0, lo};
      c = v & ~(sz - 1);
      l = c + sz - 1;
      if (me && (!rom || lo[0]) && c != 0 && l > c && l != ONES &&
          (m64 || l < 64'hFFFF_FFFF)) m = 1;
    end
    if (m) b = c;
  endfunction

  task automatic drive(input string tag, input logic [31:0] lo, hi, input logic [63:0] sz,
                       input logic io, m64, rom, ioe, me);
    exp_t e;
    logic [63:0] b;
    logic m;
    @(negedge clk);
    bar_lo = lo; bar_hi = hi; region_size = sz;
    is_io = io; is_mem64 = m64; is_rom = rom; io_space_en = ioe; mem_space_en = me;
    model(lo, hi, sz, io, m64, rom, ioe, me, b, m);
    e.base = b; e.map = m; e.upd = (b != prev_base) || (m != prev_map); e.tag = tag;
    prev_base = b; prev_map = m;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        compared++;
        if (base_addr !== e.base || mapped !== e.map || update !== e.upd) begin
          mismatched++;
          $display("FAIL %s: got base=%h map=%0b upd=%0b exp base=%h map=%0b upd=%0b",
                   e.tag, base_addr, mapped, update, e.base, e.map, e.upd);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got hung exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #5;
    compared++;
    if (base_addr !== ONES || mapped !== 0 || update !== 0) begin
      mismatched++;
      $display("FAIL R1 reset: got base=%h map=%0b upd=%0b exp base=%h map=0 upd=0",
               base_addr, mapped, update, ONES);
    end
    @(negedge clk) rst_n = 1;
    // R1 idle after reset: size zero, nothing changes
    drive("R1 idle", 32'h0, 32'h0, 64'h0, 1, 0, 0, 0, 0);
    // R3/R11 I/O decode, low bit cleared
    drive("R3 R11 io map", 32'h0000_C001, 32'h0, 64'h20, 1, 0, 0, 1, 1);
    drive("R9 hold no pulse", 32'h0000_C001, 32'h0, 64'h20, 1, 0, 0, 1, 1);
    drive("R3 hi ignored io", 32'h0000_C001, 32'h55, 64'h20, 1, 0, 0, 1, 1);
    drive("R2 io disabled", 32'h0000_C001, 32'h0, 64'h20, 1, 0, 0, 0, 1);
    drive("R4 io top edge", 32'h0000_FFF0, 32'h0, 64'h20, 1, 0, 0, 1, 0);
    drive("R4 io above ceiling", 32'h0001_0000, 32'h0, 64'h20, 1, 0, 0, 1, 1);
    drive("R4 io zero base", 32'h0000_0001, 32'h0, 64'h20, 1, 0, 0, 1, 1);
    drive("R4 io size one", 32'h0000_0100, 32'h0, 64'h1, 1, 0, 0, 1, 1);
    drive("R2 mem disabled", 32'hFEBF_0000, 32'h0, 64'h1000, 0, 0, 0, 1, 0);
    drive("R3 mem32 map", 32'hFEBF_0008, 32'h0, 64'h1000, 0, 0, 0, 0, 1);
    drive("R7 mem32 top", 32'hFFFF_F000, 32'h0, 64'h1000, 0, 0, 0, 1, 1);
    drive("R3 mem32 hi ignored", 32'h8000_0000, 32'h12, 64'h1000, 0, 0, 0, 1, 1);
    drive("R3 mem64 map", 32'h4000_000C, 32'h1, 64'h100_0000, 0, 1, 0, 1, 1);
    drive("R6 mem64 all ones", 32'hFFFF_F000, 32'hFFFF_FFFF, 64'h1000, 0, 1, 0, 1, 1);
    drive("R7 mem64 past 4G edge", 32'hFFFF_F000, 32'h0, 64'h1000, 0, 1, 0, 1, 1);
    drive("R6 mem zero base", 32'h0000_0004, 32'h0, 64'h1000, 0, 0, 0, 1, 1);
    drive("R5 rom off", 32'h000C_0000, 32'h0, 64'h2_0000, 0, 0, 1, 1, 1);
    drive("R5 rom on", 32'h000C_0001, 32'h0, 64'h2_0000, 0, 0, 1, 1, 1);
    drive("R2 rom mem disabled", 32'h000C_0001, 32'h0, 64'h2_0000, 0, 0, 1, 1, 0);
    drive("R10 size zero", 32'h0000_C001, 32'h0, 64'h0, 1, 0, 0, 1, 1);
    drive("R10 size zero mem", 32'h8000_0000, 32'h0, 64'h0, 0, 0, 0, 1, 1);
    drive("R10 size zero rom", 32'h000C_0001, 32'h0, 64'h0, 0, 1, 1, 1, 1);
    drive("R8 R9 remap", 32'h0000_D000, 32'h0, 64'h100, 1, 0, 0, 1, 0);
    drive("R9 base move", 32'h0000_E000, 32'h0, 64'h100, 1, 0, 0, 1, 0);
    drive("R9 steady", 32'h0000_E000, 32'h0, 64'h100, 1, 0, 0, 1, 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule